// File: doc/BRIEF.md
# Burst Ramp and Transmit Sequencer

This block runs the life cycle of a burst-mode baseband transmit path. After the power enable is raised it waits out a fixed calibration interval and then raises a ready flag. A rising burst request taken while ready is high starts a burst. The block generates the serial bit clock that paces the data source. It tells the modulator to send zero symbols during the opening ramp. It scales the incoming shaped I/Q samples by a raised-cosine amplitude envelope, so that the burst fades in over two symbols and fades out over two symbols.

When the burst request falls, the dibit in progress is finished. Four more dibits (eight bit clocks) follow. The first two of these carry the fade-out and the last two are sent at zero amplitude. Ready then returns high. A copy of the burst request, delayed by a fixed number of master clocks, is output so that a power amplifier can be switched in step with the analog chain. Dropping the power enable puts the block to sleep at once, with every output idle.

One symbol (dibit) lasts 128 master clocks, which is two bit-clock periods. The envelope is a 32-step table over the two-symbol ramp, so each step lasts 8 master clocks.

Top module: `burst_ramp_sequencer`

## Requirements
- R1: During reset, and on the master clock after any rising edge that samples `power_en` low, the outputs `ready`, `bit_clk`, `burst_out`, `mod_zero`, `env_gain`, `i_out` and `q_out` are all zero.
- R2: `ready` rises on the rising edge that comes CAL_CYCLES (4096) edges after the first edge that samples `power_en` high. It stays low until then.
- R3: A rising edge that samples `burst_in` high, where the previous sample was low, while `ready` is high makes `ready` low after that edge. `bit_clk` stays low after that edge and after the next one. `bit_clk` is first high after the second edge following the start edge. That point is burst cycle j = 0.
- R4: During a burst, including its tail, `bit_clk` has a period of 64 master clocks. It is high for the first 32 clocks of each period, counted from j = 0, and it is low whenever `ready` is high.
- R5: In burst cycle j < 256, `env_gain` = round(1024·(0.5 − 0.5·cos(π·floor(j/8)/32))) and `mod_zero` is 1. From j = 256 on, `env_gain` = 1024 (full scale) and `mod_zero` is 0.
- R6: The tail starts at the first dibit boundary after the rising edge that samples `burst_in` low. This is cycle j* + 1, where j* is the smallest j ≥ the drop cycle with j mod 128 = 127. In tail cycle k < 256, `env_gain` = round(1024·(0.5 + 0.5·cos(π·floor(k/8)/32))). For 256 ≤ k < 512, `env_gain` = 0. `bit_clk` keeps running and `mod_zero` is 0.
- R7: `ready` returns high, with `bit_clk` low and `env_gain` 0, at tail cycle k = 512. This is after the last of the eight trailing bit clocks.
- R8: `burst_out` sampled before any rising edge equals `burst_in` sampled 480 master clocks earlier, while powered.
- R9: A `burst_in` rise seen while `ready` is low is ignored. This covers a rise during calibration and a rise during the tail. If `burst_in` is still held high when `ready` rises, no burst starts.
- R10: `i_out` = floor((`i_in`·`env_gain` + 512) / 1024), and the same for `q_out`. Samples are two's-complement 10-bit, and `env_gain` is unsigned with 1024 meaning unity.
- R11: If `power_en` falls during a burst, the burst is abandoned. All outputs are idle after the next edge, and a later power-up repeats the full calibration wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| power_en | input | 1 | Power enable; low means sleep |
| burst_in | input | 1 | Burst request; rise starts, fall ends a burst |
| i_in | input | 10 | Shaped in-phase sample, two's complement |
| q_in | input | 10 | Shaped quadrature sample, two's complement |
| bit_clk | output | 1 | Serial transmit bit clock |
| ready | output | 1 | Calibrated and idle, a burst may start |
| burst_out | output | 1 | Burst request delayed by 480 master clocks |
| mod_zero | output | 1 | Modulator must send zero symbols |
| env_gain | output | 11 | Envelope gain, 1024 = unity |
| i_out | output | 10 | Envelope-scaled in-phase sample |
| q_out | output | 10 | Envelope-scaled quadrature sample |

## Verification
A wrong phase counter shows on `bit_clk` within one master clock, and at the latest on the next 32-clock edge. A wrong ramp counter shows as a wrong `env_gain` step, and so as wrong `i_out` and `q_out`, within 8 clocks. A misplaced tail start or tail length moves the return of `ready` by a whole dibit (128 clocks), which the ready check catches in the exact cycle. The bench checks every cycle of each burst against the cosine formula and the rounding rule. It sweeps drop points inside a dibit, on its last cycle and just after the boundary, and inside the ramp-up. A fault in the delay chain shows on `burst_out` exactly 480 clocks after the burst request changes.

// File: rtl/brs_pkg.sv
// Shared types and elaboration-time helpers for the burst ramp sequencer.
// Assumes: real arithmetic is used only in constant (elaboration) context.
package brs_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_CAL,
        ST_READY,
        ST_START,
        ST_ACTIVE,
        ST_TAIL
    } brs_state_t;

    // Rising raised-cosine gain at table step idx of entries, scaled to full.
    function automatic int ramp_rise_value(input int idx, input int entries, input int full);
        real ang;
        ang = 3.14159265358979 * $itor(idx) / $itor(entries);
        return $rtoi($itor(full) * (0.5 - 0.5 * $cos(ang)) + 0.5);
    endfunction

endpackage

// File: rtl/brs_seq_ctrl.sv
// Sequencer state machine: sleep, calibration wait, ready, start delay,
// active burst with ramp-up, and fixed-length tail with ramp-down.
// Assumes: SYM_CLKS = 4 * BCLK_HALF (one dibit = two bit-clock periods).
module brs_seq_ctrl
    import brs_pkg::*;
#(
    parameter int CAL_CYCLES = 4096,
    parameter int START_WAIT = 2,
    parameter int BCLK_HALF  = 32,
    parameter int RAMP_SYMS  = 2,
    parameter int TAIL_SYMS  = 4,
    localparam int SYM_CLKS  = 4 * BCLK_HALF,
    localparam int RAMP_LEN  = RAMP_SYMS * SYM_CLKS,
    localparam int RC_W      = $clog2(RAMP_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             power_en,
    input  logic             burst_in,
    output brs_state_t       state_o,
    output logic [RC_W-1:0]  ramp_cnt_o,
    output logic             ready,
    output logic             bit_clk,
    output logic             mod_zero
);
    localparam int PH_W  = $clog2(SYM_CLKS);
    localparam int CAL_W = $clog2(CAL_CYCLES + 1);
    localparam int SW_W  = $clog2(START_WAIT + 1);
    localparam int TS_W  = $clog2(TAIL_SYMS + 1);

    brs_state_t        state;
    logic [CAL_W-1:0]  cal_cnt;
    logic [SW_W-1:0]   wait_cnt;
    logic [PH_W-1:0]   phase;
    logic [RC_W-1:0]   ramp_cnt;
    logic [TS_W-1:0]   tail_sym;
    logic              stop_req;
    logic              bin_q;
    logic              sym_end;

    assign sym_end = (phase == PH_W'(SYM_CLKS - 1));

    // Advance the burst life cycle by one master clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_SLEEP;
            cal_cnt  <= '0;
            wait_cnt <= '0;
            phase    <= '0;
            ramp_cnt <= '0;
            tail_sym <= '0;
            stop_req <= 1'b0;
            bin_q    <= 1'b0;
        end else begin
            bin_q <= burst_in;
            if (!power_en) begin
                state    <= ST_SLEEP;
                cal_cnt  <= '0;
                stop_req <= 1'b0;
            end else begin
                case (state)
                    ST_SLEEP: begin
                        state   <= ST_CAL;
                        cal_cnt <= '0;
                    end
                    ST_CAL: begin
                        if (cal_cnt == CAL_W'(CAL_CYCLES - 1)) state <= ST_READY;
                        else cal_cnt <= cal_cnt + 1'b1;
                    end
                    ST_READY: begin
                        if (burst_in && !bin_q) begin
                            state    <= ST_START;
                            wait_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (wait_cnt == SW_W'(START_WAIT - 1)) begin
                            state    <= ST_ACTIVE;
                            phase    <= '0;
                            ramp_cnt <= '0;
                            stop_req <= 1'b0;
                        end else begin
                            wait_cnt <= wait_cnt + 1'b1;
                        end
                    end
                    ST_ACTIVE: begin
                        phase <= sym_end ? '0 : phase + 1'b1;
                        if (ramp_cnt != RC_W'(RAMP_LEN)) ramp_cnt <= ramp_cnt + 1'b1;
                        if (!burst_in) stop_req <= 1'b1;
                        if (sym_end && (stop_req || !burst_in)) begin
                            state    <= ST_TAIL;
                            ramp_cnt <= '0;
                            tail_sym <= '0;
                        end
                    end
                    ST_TAIL: begin
                        phase <= sym_end ? '0 : phase + 1'b1;
                        if (ramp_cnt != RC_W'(RAMP_LEN)) ramp_cnt <= ramp_cnt + 1'b1;
                        if (sym_end) begin
                            if (tail_sym == TS_W'(TAIL_SYMS - 1)) state <= ST_READY;
                            else tail_sym <= tail_sym + 1'b1;
                        end
                    end
                    default: state <= ST_SLEEP;
                endcase
            end
        end
    end

    // Decode the control outputs from the current state and counters.
    always_comb begin
        ready    = (state == ST_READY);
        bit_clk  = ((state == ST_ACTIVE) || (state == ST_TAIL)) &&
                   ((phase % PH_W'(2 * BCLK_HALF)) < PH_W'(BCLK_HALF));
        mod_zero = (state == ST_START) ||
                   ((state == ST_ACTIVE) && (ramp_cnt < RC_W'(RAMP_LEN)));
    end

    assign state_o    = state;
    assign ramp_cnt_o = ramp_cnt;

endmodule

// File: rtl/brs_envelope.sv
// Envelope gain lookup: raised-cosine rise in the active ramp, its
// complement in the tail, unity after the rise, zero after the fall.
// Assumes: RAMP_LEN is a power-of-two multiple of RAMP_ENTRIES.
module brs_envelope
    import brs_pkg::*;
#(
    parameter int RAMP_ENTRIES = 32,
    parameter int RAMP_LEN     = 256,
    parameter int GAIN_FRAC    = 10,
    localparam int RC_W        = $clog2(RAMP_LEN + 1),
    localparam int GW          = GAIN_FRAC + 1
) (
    input  brs_state_t       state,
    input  logic [RC_W-1:0]  ramp_cnt,
    output logic [GW-1:0]    gain
);
    localparam int IDX_W   = $clog2(RAMP_ENTRIES);
    localparam int STEP_SH = $clog2(RAMP_LEN / RAMP_ENTRIES);
    localparam int FULL    = 1 << GAIN_FRAC;

    logic [GW-1:0]    rise_tab [RAMP_ENTRIES];
    logic [RC_W-1:0]  ramp_step;
    logic [IDX_W-1:0] idx;
    logic             ramp_done;

    for (genvar k = 0; k < RAMP_ENTRIES; k++) begin : g_tab
        localparam int V = ramp_rise_value(k, RAMP_ENTRIES, FULL);
        assign rise_tab[k] = GW'(V);
    end

    assign ramp_step = ramp_cnt >> STEP_SH;
    assign idx       = ramp_step[IDX_W-1:0];
    assign ramp_done = (ramp_step >= RC_W'(RAMP_ENTRIES));

    // Select the gain for the current phase of the burst.
    always_comb begin
        case (state)
            ST_ACTIVE: gain = ramp_done ? GW'(FULL) : rise_tab[idx];
            ST_TAIL:   gain = ramp_done ? '0 : (GW'(FULL) - rise_tab[idx]);
            default:   gain = '0;
        endcase
    end

endmodule

// File: rtl/brs_scaler.sv
// Multiplies one signed sample by the unsigned envelope gain and rounds
// half up back to the sample width. Assumes gain never exceeds unity.
module brs_scaler #(
    parameter int SAMPLE_W  = 10,
    parameter int GAIN_FRAC = 10,
    localparam int GW       = GAIN_FRAC + 1
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic        [GW-1:0]       gain_i,
    output logic signed [SAMPLE_W-1:0] sample_o
);
    localparam int PW = SAMPLE_W + GW + 1;
    localparam logic signed [PW-1:0] HALF_LSB = PW'(1) << (GAIN_FRAC - 1);

    logic signed [PW-1:0] s_ext, g_ext, prod, rnd;

    // Widen, multiply, add the rounding constant and drop fraction bits.
    always_comb begin
        s_ext    = {{(PW - SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
        g_ext    = {{(PW - GW){1'b0}}, gain_i};
        prod     = s_ext * g_ext;
        rnd      = prod + HALF_LSB;
        sample_o = rnd[GAIN_FRAC +: SAMPLE_W];
    end

endmodule

// File: rtl/brs_burst_delay.sv
// Fixed-length delay line for the burst request; cleared while asleep.
// Assumes DELAY >= 2.
module brs_burst_delay #(
    parameter int DELAY = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic din,
    output logic dout
);
    logic [DELAY-1:0] chain;

    // Shift the request one stage per master clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) chain <= '0;
        else                 chain <= {chain[DELAY-2:0], din};
    end

    assign dout = chain[DELAY-1];

endmodule

// File: rtl/burst_ramp_sequencer.sv
// Top level: sequencer, envelope lookup, per-channel scalers and the
// delayed burst output. Assumes inputs are synchronous to clk.
module burst_ramp_sequencer
    import brs_pkg::*;
#(
    parameter int SAMPLE_W     = 10,
    parameter int GAIN_FRAC    = 10,
    parameter int BCLK_HALF    = 32,
    parameter int START_WAIT   = 2,
    parameter int CAL_CYCLES   = 4096,
    parameter int RAMP_SYMS    = 2,
    parameter int TAIL_SYMS    = 4,
    parameter int RAMP_ENTRIES = 32,
    parameter int BURST_DELAY  = 480
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       power_en,
    input  logic                       burst_in,
    input  logic signed [SAMPLE_W-1:0] i_in,
    input  logic signed [SAMPLE_W-1:0] q_in,
    output logic                       bit_clk,
    output logic                       ready,
    output logic                       burst_out,
    output logic                       mod_zero,
    output logic [GAIN_FRAC:0]         env_gain,
    output logic signed [SAMPLE_W-1:0] i_out,
    output logic signed [SAMPLE_W-1:0] q_out
);
    localparam int SYM_CLKS = 4 * BCLK_HALF;
    localparam int RAMP_LEN = RAMP_SYMS * SYM_CLKS;
    localparam int RC_W     = $clog2(RAMP_LEN + 1);
    localparam int NCH      = 2;

    brs_state_t                 state;
    logic [RC_W-1:0]            ramp_cnt;
    logic                       dly_out;
    logic signed [SAMPLE_W-1:0] ch_in  [NCH];
    logic signed [SAMPLE_W-1:0] ch_out [NCH];

    brs_seq_ctrl #(
        .CAL_CYCLES (CAL_CYCLES),
        .START_WAIT (START_WAIT),
        .BCLK_HALF  (BCLK_HALF),
        .RAMP_SYMS  (RAMP_SYMS),
        .TAIL_SYMS  (TAIL_SYMS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_en   (power_en),
        .burst_in   (burst_in),
        .state_o    (state),
        .ramp_cnt_o (ramp_cnt),
        .ready      (ready),
        .bit_clk    (bit_clk),
        .mod_zero   (mod_zero)
    );

    brs_envelope #(
        .RAMP_ENTRIES (RAMP_ENTRIES),
        .RAMP_LEN     (RAMP_LEN),
        .GAIN_FRAC    (GAIN_FRAC)
    ) u_env (
        .state    (state),
        .ramp_cnt (ramp_cnt),
        .gain     (env_gain)
    );

    assign ch_in[0] = i_in;
    assign ch_in[1] = q_in;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        brs_scaler #(
            .SAMPLE_W  (SAMPLE_W),
            .GAIN_FRAC (GAIN_FRAC)
        ) u_scale (
            .sample_i (ch_in[c]),
            .gain_i   (env_gain),
            .sample_o (ch_out[c])
        );
    end

    assign i_out = ch_out[0];
    assign q_out = ch_out[1];

    brs_burst_delay #(
        .DELAY (BURST_DELAY)
    ) u_bdly (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_SLEEP),
        .din   (burst_in),
        .dout  (dly_out)
    );

    // The delayed burst flag is forced idle while asleep.
    assign burst_out = dly_out && (state != ST_SLEEP);

endmodule

// File: rtl/brs_checker.sv
// Port-level temporal checks for burst_ramp_sequencer, attached by bind.
module brs_checker #(
    parameter int SAMPLE_W  = 10,
    parameter int GAIN_FRAC = 10
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       power_en,
    input logic                       burst_in,
    input logic signed [SAMPLE_W-1:0] i_in,
    input logic signed [SAMPLE_W-1:0] q_in,
    input logic                       bit_clk,
    input logic                       ready,
    input logic                       burst_out,
    input logic                       mod_zero,
    input logic [GAIN_FRAC:0]         env_gain,
    input logic signed [SAMPLE_W-1:0] i_out,
    input logic signed [SAMPLE_W-1:0] q_out
);
    localparam logic [GAIN_FRAC:0] FULL = (GAIN_FRAC + 1)'(1) << GAIN_FRAC;

    assert_sleep_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(power_en) |-> (!ready && !bit_clk && !burst_out && !mod_zero && env_gain == '0));

    assert_start_drops_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && burst_in && !$past(burst_in) && power_en) |=> !ready);

    assert_ready_no_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!bit_clk && !mod_zero && env_gain == '0));

    assert_ramp_below_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mod_zero |-> (env_gain < FULL));

    assert_gain_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        env_gain <= FULL);

    assert_unity_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (env_gain == FULL) |-> (i_out == i_in && q_out == q_in));

    assert_zero_gain_mutes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (env_gain == '0) |-> (i_out == '0 && q_out == '0));

endmodule

bind burst_ramp_sequencer brs_checker #(
    .SAMPLE_W  (SAMPLE_W),
    .GAIN_FRAC (GAIN_FRAC)
) u_brs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .power_en  (power_en),
    .burst_in  (burst_in),
    .i_in      (i_in),
    .q_in      (q_in),
    .bit_clk   (bit_clk),
    .ready     (ready),
    .burst_out (burst_out),
    .mod_zero  (mod_zero),
    .env_gain  (env_gain),
    .i_out     (i_out),
    .q_out     (q_out)
);

// File: tb/burst_ramp_sequencer_bench.sv
module burst_ramp_sequencer_bench;
    localparam int CAL   = 4096;
    localparam int SYM   = 128;
    localparam int RAMP  = 256;
    localparam int TAILN = 512;
    localparam int DLY   = 480;
    localparam int FULL  = 1024;
    localparam int HN    = 1024;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n, power_en, burst_in;
    logic signed [9:0] i_in, q_in, i_out, q_out;
    logic              bit_clk, ready, burst_out, mod_zero;
    logic [10:0]       env_gain;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit bo_chk = 1'b0;
    logic bhist [HN];

    burst_ramp_sequencer u_burst_ramp_sequencer (
        .clk(clk), .rst_n(rst_n), .power_en(power_en), .burst_in(burst_in),
        .i_in(i_in), .q_in(q_in), .bit_clk(bit_clk), .ready(ready),
        .burst_out(burst_out), .mod_zero(mod_zero), .env_gain(env_gain),
        .i_out(i_out), .q_out(q_out)
    );

    function automatic int rise_g(int j);
        return $rtoi(1024.0 * (0.5 - 0.5 * $cos(3.14159265358979 * $itor(j / 8) / 32.0)) + 0.5);
    endfunction

    function automatic int fall_g(int k);
        return $rtoi(1024.0 * (0.5 + 0.5 * $cos(3.14159265358979 * $itor(k / 8) / 32.0)) + 0.5);
    endfunction

    function automatic int scale(int s, int g);
        int p;
        p = s * g + 512;
        return p >>> 10;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // One master clock: log the driven request, step, check the delayed flag, drive samples.
    task automatic tick();
        int sidx;
        bhist[cyc % HN] = burst_in;
        @(posedge clk);
        #2;
        cyc++;
        if (bo_chk && cyc >= DLY) begin
            sidx = (cyc - DLY) % HN;
            check(burst_out == bhist[sidx], "R8", "burst_out delay", int'(burst_out), int'(bhist[sidx]));
        end
        i_in = 10'(((cyc * 73) % 1024) - 512);
        q_in = 10'(511 - ((cyc * 151) % 1024));
        #1;
    endtask

    task automatic check_samples(input int g, input string req);
        check(int'(env_gain) == g, req, "env_gain", int'(env_gain), g);
        check(int'(i_out) == scale(int'(i_in), g), "R10", "i_out", int'(i_out), scale(int'(i_in), g));
        check(int'(q_out) == scale(int'(q_in), g), "R10", "q_out", int'(q_out), scale(int'(q_in), g));
    endtask

    task automatic run_burst(input int drop_j, input bit reraise);
        int jstar;
        check(ready == 1'b1, "R3", "ready before start", int'(ready), 1);
        burst_in = 1'b1;
        tick();
        check(ready == 1'b0, "R3", "ready after start edge", int'(ready), 0);
        check(bit_clk == 1'b0, "R3", "bit_clk first wait", int'(bit_clk), 0);
        tick();
        check(bit_clk == 1'b0, "R3", "bit_clk second wait", int'(bit_clk), 0);
        jstar = drop_j + (127 - (drop_j % SYM));
        for (int j = 0; j <= jstar; j++) begin
            tick();
            check(bit_clk == ((j % 64) < 32), "R4", "bit_clk active", int'(bit_clk), int'((j % 64) < 32));
            check(mod_zero == (j < RAMP), "R5", "mod_zero", int'(mod_zero), int'(j < RAMP));
            check(ready == 1'b0, "R3", "ready during burst", int'(ready), 0);
            check_samples((j < RAMP) ? rise_g(j) : FULL, "R5");
            if (j == drop_j) burst_in = 1'b0;
        end
        for (int k = 0; k < TAILN; k++) begin
            tick();
            check(bit_clk == ((k % 64) < 32), "R4", "bit_clk tail", int'(bit_clk), int'((k % 64) < 32));
            check(mod_zero == 1'b0, "R6", "mod_zero tail", int'(mod_zero), 0);
            check(ready == 1'b0, "R7", "ready in tail", int'(ready), 0);
            check_samples((k < RAMP) ? fall_g(k) : 0, "R6");
            if (reraise && k == 100) burst_in = 1'b1;
        end
        tick();
        check(ready == 1'b1, "R7", "ready after tail", int'(ready), 1);
        check(bit_clk == 1'b0, "R7", "bit_clk after tail", int'(bit_clk), 0);
        check(env_gain == 11'd0, "R7", "gain after tail", int'(env_gain), 0);
        if (reraise) begin
            repeat (10) begin
                tick();
                check(ready == 1'b1 && bit_clk == 1'b0, "R9", "held request after tail", int'(ready), 1);
            end
            burst_in = 1'b0;
        end
        repeat (5) tick();
    endtask

    initial begin
        int n0;
        rst_n = 1'b0; power_en = 1'b0; burst_in = 1'b0;
        i_in = '0; q_in = '0;
        for (int i = 0; i < HN; i++) bhist[i] = 1'b0;
        repeat (3) tick();
        check(!ready && !bit_clk && !burst_out && !mod_zero && env_gain == 11'd0, "R1",
              "idle in reset", int'(ready) + int'(bit_clk) + int'(env_gain), 0);
        check(i_out == 10'sd0 && q_out == 10'sd0, "R1", "samples in reset", int'(i_out), 0);
        rst_n = 1'b1;
        bo_chk = 1'b1;
        repeat (3) tick();
        check(!ready && !bit_clk && env_gain == 11'd0, "R1", "idle while power low", int'(ready), 0);

        // Power up; a request raised during calibration must be ignored.
        power_en = 1'b1;
        n0 = cyc;
        while (cyc < n0 + CAL) begin
            tick();
            if (cyc == n0 + 10) burst_in = 1'b1;
        end
        check(ready == 1'b0, "R2", "ready before cal end", int'(ready), 0);
        tick();
        check(ready == 1'b1, "R2", "ready at cal end", int'(ready), 1);
        repeat (20) begin
            tick();
            check(ready == 1'b1 && bit_clk == 1'b0, "R9", "request held from calibration", int'(ready), 1);
        end
        burst_in = 1'b0;
        repeat (3) tick();

        run_burst(300, 1'b0);
        run_burst(383, 1'b0);
        run_burst(384, 1'b1);
        run_burst(10, 1'b0);

        // Power loss in the middle of a burst.
        bo_chk = 1'b0;
        burst_in = 1'b1;
        repeat (60) tick();
        check(bit_clk == 1'b1 || bit_clk == 1'b0, "R11", "burst running", 0, 0);
        power_en = 1'b0;
        tick();
        check(!ready && !bit_clk && !burst_out && !mod_zero, "R11", "idle after power drop",
              int'(ready) + int'(bit_clk) + int'(burst_out), 0);
        check_samples(0, "R11");
        burst_in = 1'b0;
        tick();
        power_en = 1'b1;
        n0 = cyc;
        while (cyc < n0 + CAL) tick();
        check(ready == 1'b0, "R11", "recalibration not done", int'(ready), 0);
        tick();
        check(ready == 1'b1, "R11", "recalibration done", int'(ready), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule